// File: doc/BRIEF.md
# Multiplexed Bus Demultiplexer and Decoder

This block joins an 8-bit processor whose low address byte and data share eight lines to a plain system bus. An address-latch-enable strobe, active high, marks the part of each cycle in which the shared lines carry the address. While it is high, the low address byte passes straight through. When it drops, the low byte holds the value that was captured. That byte is placed under the dedicated high address byte to form a 16-bit address covering 0000h to FFFFh.

A memory/I-O select line (0 = memory, 1 = I/O port) is combined with the active-low read and write strobes. The result is four exclusive active-low cycle strobes. In I/O-port cycles the 8-bit port number is the latched low byte. The block also drives two enables for the data path, one toward the processor and one toward the system, so that the shared lines can be tristated.

Decode produces three active-low selects. The first is for one memory region. The other two are for a two-address memory-mapped I/O window: its base address is the input register and base+1 is the output register.

Top module: `busdmx_top`

## Requirements
- R1: While rst_ni is low, the held low address byte is cleared, so addr_o[7:0] reads 00h whenever ale_i is low.
- R2: addr_o[15:8] always equals addr_hi_i. While ale_i is high, addr_o[7:0] equals ad_i in the same cycle.
- R3: While ale_i is low, addr_o[7:0] keeps the ad_i value sampled at the last rising clock edge at which ale_i was high, whatever ad_i does afterwards.
- R4: With io_m_i = 0, rd_ni low alone drives mem_rd_no low, and wr_ni low alone drives mem_wr_no low.
- R5: With io_m_i = 1, rd_ni low alone drives io_rd_no low and wr_ni low alone drives io_wr_no low. port_o always equals addr_o[7:0].
- R6: At most one of the four cycle strobes is low. When rd_ni and wr_ni are both low, all four stay high and conflict_o is 1. Otherwise conflict_o is 0.
- R7: cpu_data_oe_o is 1 exactly when rd_ni is low and wr_ni is high. cpu_data_o always equals sys_rdata_i.
- R8: sys_wdata_oe_o is 1 exactly when wr_ni is low and rd_ni is high. sys_wdata_o always equals ad_i.
- R9: mem_cs_no is low exactly when io_m_i = 0, addr_o lies in MEM_BASE .. MEM_BASE + 2^MEM_SIZE_LOG2 - 1 (default 0000h..7FFFh), and addr_o is neither MMIO_BASE nor MMIO_BASE+1.
- R10: mmio_in_cs_no is low exactly during a memory read at MMIO_BASE (default 8000h). mmio_out_cs_no is low exactly during a memory write at MMIO_BASE+1. I/O-port cycles never assert either select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ale_i | input | 1 | Address latch enable, high while the shared lines carry the address |
| ad_i | input | 8 | Shared low-address/data lines from the processor |
| addr_hi_i | input | 8 | High address byte |
| io_m_i | input | 1 | 0 = memory cycle, 1 = I/O-port cycle |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low |
| sys_rdata_i | input | 8 | Read data from the system bus |
| addr_o | output | 16 | Demultiplexed address |
| port_o | output | 8 | I/O port number |
| mem_rd_no | output | 1 | Memory read strobe, active low |
| mem_wr_no | output | 1 | Memory write strobe, active low |
| io_rd_no | output | 1 | I/O read strobe, active low |
| io_wr_no | output | 1 | I/O write strobe, active low |
| conflict_o | output | 1 | Read and write asserted together |
| cpu_data_o | output | 8 | Data toward the processor |
| cpu_data_oe_o | output | 1 | Drive enable toward the processor |
| sys_wdata_o | output | 8 | Write data toward the system bus |
| sys_wdata_oe_o | output | 1 | Drive enable toward the system bus |
| mem_cs_no | output | 1 | Memory region select, active low |
| mmio_in_cs_no | output | 1 | Mapped input register select, active low |
| mmio_out_cs_no | output | 1 | Mapped output register select, active low |

## Verification
Address capture and strobe generation can fall in the same cycle when the processor raises the latch enable while a read or write strobe is still low. In that case the decode and port number must follow the live lines, not the held byte. The bench provokes this with a directed read in which ale_i stays high, and the lines change across several strobe cycles. Random vectors with an independent ale_i add further cases. A per-cycle model predicts every output from the inputs and from a held byte, which the model updates only on edges where ale_i was high. All outputs are compared against that model in the middle of each cycle.

// File: rtl/busdmx_pkg.sv
`timescale 1ns/1ps
package busdmx_pkg;
  typedef enum logic [2:0] {
    CYC_IDLE,
    CYC_MEM_RD,
    CYC_MEM_WR,
    CYC_IO_RD,
    CYC_IO_WR,
    CYC_CONFLICT
  } cyc_e;
endpackage

// File: rtl/busdmx_ad_latch.sv
`timescale 1ns/1ps
module busdmx_ad_latch #(
  parameter int unsigned LO_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ale_i,
  input  logic [LO_W-1:0] ad_i,
  output logic [LO_W-1:0] lo_o
);
  logic [LO_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    lo_q <= '0;
    else if (ale_i) lo_q <= ad_i;
  end

  // transparent while ale high, held otherwise
  assign lo_o = ale_i ? ad_i : lo_q;

  a_r3_hold_when_closed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i && $past(!ale_i)) |-> $stable(lo_o));
endmodule

// File: rtl/busdmx_strobe_gen.sv
`timescale 1ns/1ps
module busdmx_strobe_gen
  import busdmx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic io_m_i,
  input  logic rd_ni,
  input  logic wr_ni,
  output cyc_e cyc_o,
  output logic mem_rd_no,
  output logic mem_wr_no,
  output logic io_rd_no,
  output logic io_wr_no,
  output logic conflict_o
);
  logic rd, wr;
  assign rd = !rd_ni;
  assign wr = !wr_ni;

  always_comb begin
    cyc_o = CYC_IDLE;
    if (rd && wr)      cyc_o = CYC_CONFLICT;
    else if (rd)       cyc_o = io_m_i ? CYC_IO_RD : CYC_MEM_RD;
    else if (wr)       cyc_o = io_m_i ? CYC_IO_WR : CYC_MEM_WR;
  end

  always_comb begin
    mem_rd_no  = 1'b1;
    mem_wr_no  = 1'b1;
    io_rd_no   = 1'b1;
    io_wr_no   = 1'b1;
    conflict_o = 1'b0;
    unique case (cyc_o)
      CYC_MEM_RD:   mem_rd_no  = 1'b0;
      CYC_MEM_WR:   mem_wr_no  = 1'b0;
      CYC_IO_RD:    io_rd_no   = 1'b0;
      CYC_IO_WR:    io_wr_no   = 1'b0;
      CYC_CONFLICT: conflict_o = 1'b1;
      default: ;
    endcase
  end

  a_r6_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~mem_rd_no, ~mem_wr_no, ~io_rd_no, ~io_wr_no}) <= 1);
  a_r6_conflict_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && !wr_ni) |-> (conflict_o && mem_rd_no && mem_wr_no && io_rd_no && io_wr_no));
  a_r4_mem_rd_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_rd_no |-> (!io_m_i && !rd_ni && wr_ni));
  a_r5_io_wr_space: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_no |-> (io_m_i && !wr_ni && rd_ni));
endmodule

// File: rtl/busdmx_addr_decode.sv
`timescale 1ns/1ps
module busdmx_addr_decode
  import busdmx_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 16,
  parameter logic [ADDR_W-1:0] MEM_BASE      = '0,
  parameter int unsigned       MEM_SIZE_LOG2 = 15,
  parameter logic [ADDR_W-1:0] MMIO_BASE     = 16'h8000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              io_m_i,
  input  cyc_e              cyc_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_cs_no,
  output logic              mmio_in_cs_no,
  output logic              mmio_out_cs_no
);
  localparam logic [ADDR_W-1:0] MMIO_OUT = MMIO_BASE + {{(ADDR_W-1){1'b0}}, 1'b1};

  logic in_region, hit_in, hit_out;

  generate
    if (MEM_SIZE_LOG2 >= ADDR_W) begin : g_full
      assign in_region = 1'b1;
    end else begin : g_part
      assign in_region = addr_i[ADDR_W-1:MEM_SIZE_LOG2] == MEM_BASE[ADDR_W-1:MEM_SIZE_LOG2];
    end
  endgenerate

  assign hit_in  = addr_i == MMIO_BASE;
  assign hit_out = addr_i == MMIO_OUT;

  // mapped window carves its two addresses out of the region
  assign mem_cs_no      = !(!io_m_i && in_region && !hit_in && !hit_out);
  assign mmio_in_cs_no  = !(cyc_i == CYC_MEM_RD && hit_in);
  assign mmio_out_cs_no = !(cyc_i == CYC_MEM_WR && hit_out);

  a_r10_io_never_mapped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_m_i |-> (mmio_in_cs_no && mmio_out_cs_no && mem_cs_no));
  a_r10_sel_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones({~mem_cs_no, ~mmio_in_cs_no, ~mmio_out_cs_no}) <= 1);
endmodule

// File: rtl/busdmx_top.sv
`timescale 1ns/1ps
module busdmx_top
  import busdmx_pkg::*;
#(
  parameter int unsigned       ADDR_W        = 16,
  parameter int unsigned       LO_W          = 8,
  parameter logic [ADDR_W-1:0] MEM_BASE      = '0,
  parameter int unsigned       MEM_SIZE_LOG2 = 15,
  parameter logic [ADDR_W-1:0] MMIO_BASE     = 16'h8000,
  localparam int unsigned      HI_W          = ADDR_W - LO_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic              io_m_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [LO_W-1:0]   sys_rdata_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LO_W-1:0]   port_o,
  output logic              mem_rd_no,
  output logic              mem_wr_no,
  output logic              io_rd_no,
  output logic              io_wr_no,
  output logic              conflict_o,
  output logic [LO_W-1:0]   cpu_data_o,
  output logic              cpu_data_oe_o,
  output logic [LO_W-1:0]   sys_wdata_o,
  output logic              sys_wdata_oe_o,
  output logic              mem_cs_no,
  output logic              mmio_in_cs_no,
  output logic              mmio_out_cs_no
);
  logic [LO_W-1:0] lo;
  cyc_e            cyc;

  busdmx_ad_latch #(.LO_W(LO_W)) u_latch (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ale_i  (ale_i),
    .ad_i   (ad_i),
    .lo_o   (lo)
  );

  busdmx_strobe_gen u_strobe (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .io_m_i     (io_m_i),
    .rd_ni      (rd_ni),
    .wr_ni      (wr_ni),
    .cyc_o      (cyc),
    .mem_rd_no  (mem_rd_no),
    .mem_wr_no  (mem_wr_no),
    .io_rd_no   (io_rd_no),
    .io_wr_no   (io_wr_no),
    .conflict_o (conflict_o)
  );

  assign addr_o = {addr_hi_i, lo};
  assign port_o = lo;

  busdmx_addr_decode #(
    .ADDR_W        (ADDR_W),
    .MEM_BASE      (MEM_BASE),
    .MEM_SIZE_LOG2 (MEM_SIZE_LOG2),
    .MMIO_BASE     (MMIO_BASE)
  ) u_decode (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .io_m_i         (io_m_i),
    .cyc_i          (cyc),
    .addr_i         (addr_o),
    .mem_cs_no      (mem_cs_no),
    .mmio_in_cs_no  (mmio_in_cs_no),
    .mmio_out_cs_no (mmio_out_cs_no)
  );

  // data steering; enables keyed off the decoded cycle
  assign cpu_data_o     = sys_rdata_i;
  assign cpu_data_oe_o  = (cyc == CYC_MEM_RD) || (cyc == CYC_IO_RD);
  assign sys_wdata_o    = ad_i;
  assign sys_wdata_oe_o = (cyc == CYC_MEM_WR) || (cyc == CYC_IO_WR);

  a_r7_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cpu_data_oe_o && sys_wdata_oe_o));
  a_r7_drive_needs_rd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_data_oe_o |-> (!rd_ni && wr_ni));
  a_r8_drive_needs_wr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_wdata_oe_o |-> (!wr_ni && rd_ni));
endmodule

// File: tb/busdmx_top_test.sv
`timescale 1ns/1ps
module busdmx_top_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ale = 1'b0;
  logic [7:0]  ad = '0;
  logic [7:0]  hi = '0;
  logic        iom = 1'b0;
  logic        rdn = 1'b1;
  logic        wrn = 1'b1;
  logic [7:0]  sysd = '0;
  logic [15:0] addr;
  logic [7:0]  port, cpu_d, sys_w;
  logic        mrd, mwr, ird, iwr, conf, cpu_oe, sys_oe, mcs, ics, ocs;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;
  logic [7:0] held = '0;

  always #5 clk = ~clk;

  busdmx_top uut (
    .clk_i(clk), .rst_ni(rst_ni), .ale_i(ale), .ad_i(ad), .addr_hi_i(hi),
    .io_m_i(iom), .rd_ni(rdn), .wr_ni(wrn), .sys_rdata_i(sysd),
    .addr_o(addr), .port_o(port), .mem_rd_no(mrd), .mem_wr_no(mwr),
    .io_rd_no(ird), .io_wr_no(iwr), .conflict_o(conf),
    .cpu_data_o(cpu_d), .cpu_data_oe_o(cpu_oe), .sys_wdata_o(sys_w),
    .sys_wdata_oe_o(sys_oe), .mem_cs_no(mcs), .mmio_in_cs_no(ics),
    .mmio_out_cs_no(ocs)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic rd, wr, mr, mw, ir, iw;
    logic [7:0] lo;
    logic [15:0] a;
    int ai;
    rd = !rdn; wr = !wrn;
    lo = ale ? ad : held;
    a  = {hi, lo};
    ai = int'(a);
    mr = !iom && rd && !wr;  mw = !iom && wr && !rd;
    ir =  iom && rd && !wr;  iw =  iom && wr && !rd;
    vectors++;
    chk("R2", "addr_hi", {8'h0, addr[15:8]}, {8'h0, hi});
    chk(ale ? "R2" : "R3", "addr_lo", {8'h0, addr[7:0]}, {8'h0, lo});
    chk("R4", "mem_rd_n", {15'h0, mrd}, {15'h0, !mr});
    chk("R4", "mem_wr_n", {15'h0, mwr}, {15'h0, !mw});
    chk("R5", "io_rd_n", {15'h0, ird}, {15'h0, !ir});
    chk("R5", "io_wr_n", {15'h0, iwr}, {15'h0, !iw});
    chk("R5", "port", {8'h0, port}, {8'h0, lo});
    chk("R6", "conflict", {15'h0, conf}, {15'h0, rd && wr});
    chk("R7", "cpu_oe", {15'h0, cpu_oe}, {15'h0, rd && !wr});
    chk("R7", "cpu_data", {8'h0, cpu_d}, {8'h0, sysd});
    chk("R8", "sys_oe", {15'h0, sys_oe}, {15'h0, wr && !rd});
    chk("R8", "sys_wdata", {8'h0, sys_w}, {8'h0, ad});
    chk("R9", "mem_cs_n", {15'h0, mcs},
        {15'h0, !(!iom && ai < 32'h8000 && ai != 32'h8000 && ai != 32'h8001)});
    chk("R10", "mmio_in_n", {15'h0, ics}, {15'h0, !(mr && ai == 32'h8000)});
    chk("R10", "mmio_out_n", {15'h0, ocs}, {15'h0, !(mw && ai == 32'h8001)});
  endtask

  task automatic step(input logic a_le, input logic [7:0] d, input logic [7:0] h,
                      input logic m, input logic r, input logic w, input logic [7:0] s);
    ale = a_le; ad = d; hi = h; iom = m; rdn = r; wrn = w; sysd = s;
    @(negedge clk);
    compare();
    @(posedge clk);
    if (rst_ni && ale) held = ad;
    #1;
  endtask

  // one full bus cycle: address phase, strobe phase, idle
  task automatic bus(input logic m, input logic [15:0] a, input logic is_wr, input logic [7:0] d);
    step(1, a[7:0], a[15:8], m, 1, 1, 8'h00);
    step(1, a[7:0], a[15:8], m, 1, 1, 8'h00);
    for (int i = 0; i < 2; i++) begin
      if (is_wr) step(0, d, a[15:8], m, 1, 0, 8'($urandom));
      else       step(0, 8'($urandom), a[15:8], m, 0, 1, d);
    end
    step(0, 8'($urandom), a[15:8], m, 1, 1, 8'h00);
  endtask

  initial begin
    #1000000;
    $display("FAIL watchdog expired");
    miscompares++;
    if (!finished) $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    // R1: reset clears held byte
    ad = 8'hA5; hi = 8'h12;
    @(negedge clk);
    vectors++;
    chk("R1", "addr_lo_reset", {8'h0, addr[7:0]}, 16'h0000);
    chk("R1", "strobes_reset", {12'h0, mrd, mwr, ird, iwr}, 16'h000F);
    @(posedge clk); #1;
    rst_ni = 1'b1;
    step(0, 8'h3C, 8'h12, 0, 1, 1, 8'h00);   // R1 held still 00

    bus(0, 16'h1234, 0, 8'h5A);   // R4 memory read in region
    bus(0, 16'h7FFF, 1, 8'hC3);   // R9 top edge of region
    bus(0, 16'h8000, 0, 8'h11);   // R10 mapped input
    bus(0, 16'h8001, 1, 8'h22);   // R10 mapped output
    bus(0, 16'h8001, 0, 8'h33);   // R10 read at output address: no select
    bus(0, 16'h8000, 1, 8'h44);   // R10 write at input address: no select
    bus(0, 16'h8002, 0, 8'h55);   // R9 outside region
    bus(1, 16'h8080, 0, 8'h66);   // R5 io read, never mapped
    bus(1, 16'h3C3C, 1, 8'h77);   // R5 io write
    bus(1, 16'h8001, 1, 8'h88);   // R10 io write at mapped address

    // R6: read and write together
    step(1, 8'h00, 8'h80, 0, 1, 1, 8'h00);
    step(0, 8'h9E, 8'h80, 0, 0, 0, 8'hF0);
    step(0, 8'h9E, 8'h80, 1, 0, 0, 8'hF0);
    step(0, 8'h00, 8'h80, 0, 1, 1, 8'h00);

    // R2/R3: ale high while read strobe active, lines moving
    step(1, 8'h55, 8'h10, 0, 0, 1, 8'hAB);
    step(1, 8'h01, 8'h80, 0, 0, 1, 8'hAC);
    step(1, 8'h00, 8'h80, 0, 0, 1, 8'hAD);
    step(0, 8'hFF, 8'h80, 0, 0, 1, 8'hAE);   // held 00 -> mapped input
    // R3: lines churn with ale low
    for (int i = 0; i < 6; i++) step(0, 8'($urandom), 8'h80, 0, 1, 1, 8'h00);

    // random mix
    for (int i = 0; i < 2000; i++)
      step(1'($urandom), 8'($urandom), (i % 3 == 0) ? 8'h80 : 8'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 8'($urandom));

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule